// File: doc/BRIEF.md
# Synchronous DRAM Burst Engine

This block behaves like the core of a clocked dynamic memory device, but the cells are a small on-chip array. A command port takes one command per rising edge. An activate command opens a row. A read or write command then names a start column. The engine steps through the burst with its own column counter, so only one column command is needed per burst.

A write burst takes one data word on every edge, starting at the edge of the write command. A read burst returns one word on every edge after a fixed latency. A mode register sets the burst length. A refresh command takes its row from an internal counter, so the caller never supplies a refresh address. A command that arrives while the engine is opening a row, or while a burst is running, is dropped, and the busy output shows when that happens.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, busy, rvalid and ref_done are low, no row is open, the burst length is 4 words, and the refresh counter is 0.
- R2: A mode command accepted while not busy loads addr[1:0] as the burst-length code: 0 gives 1 word, 1 gives 2, 2 gives 4 and 3 gives 8. The new length applies to every later read and write.
- R3: An activate command accepted while not busy opens row addr[ROW_W-1:0]. Busy is high for the ACT_CYC cycles that follow, and commands on those edges are dropped. A read or write can be accepted from edge ACT_CYC+1 after the activate. The row stays open until the next activate or refresh, and reads and writes go only to the open row.
- R4: On a read accepted at edge r, word i of the burst is driven on rdata by rising edge r+2+i. With ACT_CYC=2 and the read issued at the earliest edge, the first word appears 5 edges after the activate.
- R5: Burst columns keep every start-column bit above log2(length) and step the low log2(length) bits upward by one per word, modulo the length, beginning at the start column.
- R6: rvalid is high in exactly the cycles in which a read word is on rdata, and in no others.
- R7: A write accepted at edge w stores wdata sampled at edges w, w+1, … w+length-1 into the burst columns (R5 order) of the open row.
- R8: Busy is high from the edge after an accepted read until the edge that drives its last word, and for the length-1 edges after an accepted write. Any command sampled while busy has no effect on the row, the mode or the data.
- R9: A read or write while no row is open is ignored: it produces no rvalid and changes no stored word.
- R10: A refresh accepted while not busy closes the open row and pulses ref_done for one cycle on the next edge, with ref_row showing the counter value. The counter then advances by one and wraps to 0 after 2^ROW_W refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 refresh, 5 mode; 6 and 7 act as none |
| addr | input | max(ROW_W,COL_W) | Row for activate, start column for read/write, length code in bits 1:0 for mode |
| wdata | input | DATA_W | Write data, sampled on each edge of a write burst |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | High while rdata carries a burst word |
| busy | output | 1 | High while the engine drops incoming commands |
| ref_done | output | 1 | One-cycle pulse after a refresh |
| ref_row | output | ROW_W | Row refreshed, valid with ref_done |

## Verification
The bench builds the engine with ROW_W=3, COL_W=4 and DATA_W=8, and keeps ACT_CYC at 2. Eight rows let nine refreshes in a row show the counter wrap. Sixteen columns hold two aligned 8-word groups, so an 8-word burst that starts in the middle of a group must wrap while the bits above it stay fixed. Keeping ACT_CYC at 2 allows a direct check of the five-edge gap from activate to first word.

// File: rtl/sdre_pkg.sv
`timescale 1ns/1ps
package sdre_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_REF = 3'd4,
    CMD_MRS = 3'd5
  } sdre_cmd_e;

  localparam int BL_CODE_W = 2;

  // Words in a burst for a mode-register length code.
  function automatic int unsigned burst_words(input logic [BL_CODE_W-1:0] code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/sdre_mode_reg.sv
`timescale 1ns/1ps
module sdre_mode_reg
  import sdre_pkg::*;
#(
  parameter logic [BL_CODE_W-1:0] RST_CODE = 2'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [BL_CODE_W-1:0] code_in,
  output logic [BL_CODE_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= RST_CODE;
    else if (load) code_q <= code_in;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> code_q == $past(code_in)); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code_q)); // R8

endmodule

// File: rtl/sdre_refresh.sv
`timescale 1ns/1ps
module sdre_refresh #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic             ref_done,
  output logic [ROW_W-1:0] ref_row
);

  logic [ROW_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ref_done <= 1'b0;
      ref_row  <= '0;
    end else begin
      ref_done <= fire;
      if (fire) begin
        ref_row <= cnt_q;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ref_done && ref_row == $past(cnt_q) && cnt_q == ROW_W'($past(cnt_q) + 1'b1))); // R10

  AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !ref_done); // R10

endmodule

// File: rtl/sdre_array.sv
`timescale 1ns/1ps
module sdre_array #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int DEPTH = (1 << ROW_W) * (1 << COL_W);
  localparam int IDX_W = ROW_W + COL_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  assign wr_idx = {wr_row, wr_col};
  assign rd_idx = {rd_row, rd_col};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= mem[rd_idx];
    end
  end

endmodule

// File: rtl/sdre_seq.sv
`timescale 1ns/1ps
module sdre_seq
  import sdre_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int ADDR_W  = 4,
  parameter int ACT_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BL_CODE_W-1:0] bl_code,
  output logic                 busy,
  output logic                 mrs_fire,
  output logic                 ref_fire,
  output logic                 wr_en,
  output logic [COL_W-1:0]     wr_col,
  output logic                 rd_en,
  output logic [COL_W-1:0]     rd_col,
  output logic [ROW_W-1:0]     row_q
);

  localparam int ACT_W  = $clog2(ACT_CYC + 1);
  localparam int BEAT_W = 4;

  typedef enum logic [2:0] {S_IDLE, S_ACTV, S_OPEN, S_RLAT, S_RBURST, S_WBURST} st_e;

  // Low-order column bits that move inside an aligned burst.
  function automatic logic [COL_W-1:0] low_mask(input logic [BL_CODE_W-1:0] code);
    return COL_W'(burst_words(code) - 1);
  endfunction

  // Next column: high bits held, low bits count modulo the burst length.
  function automatic logic [COL_W-1:0] burst_next(input logic [COL_W-1:0] col,
                                                  input logic [BL_CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    m = low_mask(code);
    return (col & ~m) | ((col + 1'b1) & m);
  endfunction

  st_e               st;
  logic [ACT_W-1:0]  act_cnt;
  logic [COL_W-1:0]  col_q;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  start_col;
  logic              act_fire, rd_fire, wr_fire, last_beat, row_open;

  assign start_col = addr[COL_W-1:0];
  assign busy      = (st == S_ACTV) || (st == S_RLAT) || (st == S_RBURST) || (st == S_WBURST);
  assign row_open  = (st == S_OPEN);
  assign act_fire  = !busy && (cmd == CMD_ACT);
  assign ref_fire  = !busy && (cmd == CMD_REF);
  assign mrs_fire  = !busy && (cmd == CMD_MRS);
  assign rd_fire   = row_open && (cmd == CMD_RD);
  assign wr_fire   = row_open && (cmd == CMD_WR);
  assign last_beat = (beat == BEAT_W'(burst_words(bl_code) - 1));

  assign wr_en  = wr_fire || (st == S_WBURST);
  assign wr_col = (st == S_WBURST) ? col_q : start_col;
  assign rd_en  = (st == S_RBURST);
  assign rd_col = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      act_cnt <= '0;
      row_q   <= '0;
      col_q   <= '0;
      beat    <= '0;
    end else begin
      case (st)
        S_ACTV: begin
          if (act_cnt == '0) st <= S_OPEN;
          else act_cnt <= act_cnt - 1'b1;
        end
        S_RLAT: st <= S_RBURST;
        S_RBURST, S_WBURST: begin
          col_q <= burst_next(col_q, bl_code);
          beat  <= beat + 1'b1;
          if (last_beat) st <= S_OPEN;
        end
        default: begin
          if (act_fire) begin
            row_q   <= addr[ROW_W-1:0];
            act_cnt <= ACT_W'(ACT_CYC - 1);
            st      <= S_ACTV;
          end else if (ref_fire) begin
            st <= S_IDLE;
          end else if (rd_fire) begin
            col_q <= start_col;
            beat  <= '0;
            st    <= S_RLAT;
          end else if (wr_fire) begin
            col_q <= burst_next(start_col, bl_code);
            beat  <= BEAT_W'(1);
            if (bl_code != '0) st <= S_WBURST;
          end
        end
      endcase
    end
  end

  AST_ACT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> busy); // R3

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (!rd_en ##1 rd_en)); // R4

  AST_COL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !last_beat) |=> ((col_q ^ $past(col_q)) & ~low_mask(bl_code)) == '0); // R5

  AST_BUSY_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(row_q)); // R8

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R8

endmodule

// File: rtl/sdram_burst_engine.sv
`timescale 1ns/1ps
module sdram_burst_engine
  import sdre_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int DATA_W  = 8,
  parameter int ACT_CYC = 2,
  parameter logic [1:0] RST_BL_CODE = 2'd2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [2:0]                                  cmd,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  input  logic [DATA_W-1:0]                           wdata,
  output logic [DATA_W-1:0]                           rdata,
  output logic                                        rvalid,
  output logic                                        busy,
  output logic                                        ref_done,
  output logic [ROW_W-1:0]                            ref_row
);

  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [BL_CODE_W-1:0] bl_code;
  logic                 mrs_fire, ref_fire, wr_en, rd_en;
  logic [COL_W-1:0]     wr_col, rd_col;
  logic [ROW_W-1:0]     row_q;

  sdre_mode_reg #(.RST_CODE(RST_BL_CODE)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mrs_fire),
    .code_in(addr[BL_CODE_W-1:0]), .code_q(bl_code)
  );

  sdre_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .ACT_CYC(ACT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .bl_code(bl_code),
    .busy(busy), .mrs_fire(mrs_fire), .ref_fire(ref_fire),
    .wr_en(wr_en), .wr_col(wr_col), .rd_en(rd_en), .rd_col(rd_col), .row_q(row_q)
  );

  sdre_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_row(row_q), .wr_col(wr_col), .wdata(wdata),
    .rd_en(rd_en), .rd_row(row_q), .rd_col(rd_col),
    .rdata(rdata), .rvalid(rvalid)
  );

  sdre_refresh #(.ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .fire(ref_fire),
    .ref_done(ref_done), .ref_row(ref_row)
  );

  AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en)); // R6

endmodule

// File: tb/sdram_burst_engine_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_engine_tb_top;
  import sdre_pkg::*;

  localparam int ROW_W = 3;
  localparam int COL_W = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int ROWS = 8;
  localparam int COLS = 16;

  typedef struct {
    logic [7:0] d;
    int         cyc;
    string      req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cmd_i = CMD_NOP;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid, busy, ref_done;
  logic [ROW_W-1:0]  ref_row;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   rv_cnt = 0;
  int   bl = 4;
  int   orow = 0;
  logic [7:0] mm [ROWS][COLS];
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_burst_engine #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_i), .addr(addr_i), .wdata(wdata_i),
    .rdata(rdata), .rvalid(rvalid), .busy(busy), .ref_done(ref_done), .ref_row(ref_row)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected read words and compares value and arrival cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        rv_cnt++;
        if (q.size() == 0) begin
          chk(1'b0, "R6", "unexpected rvalid", rdata, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rdata == e.d, e.req, "read data", rdata, e.d);
          chk(cyc == e.cyc, e.req, "read cycle", cyc, e.cyc);
        end
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(1'b0, "R6", "missing read word at cycle", cyc, e.cyc);
      end
    end
  end

  task automatic step(input logic [2:0] c, input int a, input int d,
                      input int exp_busy = -1, input string req = "R8");
    @(negedge clk);
    if (exp_busy >= 0) chk(busy == exp_busy[0], req, "busy", busy, exp_busy);
    cmd_i   = c;
    addr_i  = a[ADDR_W-1:0];
    wdata_i = d[DATA_W-1:0];
    @(posedge clk);
    #1;
    cmd_i = CMD_NOP;
  endtask

  function automatic int bcol(input int start, input int i, input int len);
    return (start / len) * len + ((start + i) % len);
  endfunction

  task automatic act(input int row);
    step(CMD_ACT, row, 0, 0, "R3");
    orow = row;
    step(CMD_NOP, 0, 0, 1, "R3");
    step(CMD_NOP, 0, 0, 1, "R3");
  endtask

  task automatic mrs(input int code);
    step(CMD_MRS, code, 0);
    bl = 1 << code;
  endtask

  task automatic rd_burst(input int col, input string req);
    int c;
    step(CMD_RD, col, 0, 0, "R8");
    c = cyc;
    for (int i = 0; i < bl; i++) begin
      exp_t e;
      e.d   = mm[orow][bcol(col, i, bl)];
      e.cyc = c + 2 + i;
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic wr_burst(input int col, input int base, input logic [2:0] mid);
    for (int i = 0; i < bl; i++) begin
      mm[orow][bcol(col, i, bl)] = 8'(base + i);
      if (i == 0) step(CMD_WR, col, base, 0, "R8");
      else step(mid, 5, base + i, 1, "R8");
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q.size() > 0; i++) @(negedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R6", "words left unseen", q.size(), 0);
    chk(rvalid == 1'b0, "R6", "rvalid after burst", rvalid, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(rvalid == 1'b0, "R1", "rvalid after reset", rvalid, 0);
    chk(ref_done == 1'b0, "R1", "ref_done after reset", ref_done, 0);

    // R9: read with no open row after reset
    seen = rv_cnt;
    step(CMD_RD, 3, 0);
    repeat (8) @(negedge clk);
    chk(rv_cnt == seen, "R9", "rvalid with no open row", rv_cnt - seen, 0);

    // R3: activate, then a read on a busy edge is dropped
    step(CMD_ACT, 2, 0, 0, "R3");
    orow = 2;
    seen = rv_cnt;
    step(CMD_RD, 0, 0, 1, "R3");
    step(CMD_NOP, 0, 0, 1, "R3");
    step(CMD_NOP, 0, 0, 0, "R3");
    repeat (6) @(negedge clk);
    chk(rv_cnt == seen, "R3", "read during activation", rv_cnt - seen, 0);

    // R1/R7/R5: default 4-word burst, write then wrapped read
    wr_burst(4, 8'h10, CMD_NOP);
    rd_burst(6, "R5");
    drain();

    // R4: earliest read after activate: first word 5 edges later
    act(2);
    rd_burst(4, "R4");
    drain();

    // R2/R5: 8-word burst wrapping inside an aligned group
    mrs(3);
    wr_burst(8, 8'h20, CMD_NOP);
    rd_burst(13, "R5");
    drain();
    mrs(0);
    rd_burst(9, "R2");
    drain();
    mrs(1);
    rd_burst(11, "R2");
    drain();

    // R8: commands during a read burst are dropped
    mrs(2);
    step(CMD_RD, 8, 0, 0, "R8");
    begin
      int c;
      c = cyc;
      for (int i = 0; i < bl; i++) begin
        exp_t e;
        e.d = mm[orow][bcol(8, i, bl)];
        e.cyc = c + 2 + i;
        e.req = "R8";
        q.push_back(e);
      end
    end
    step(CMD_MRS, 3, 0, 1, "R8");
    step(CMD_ACT, 5, 0, 1, "R8");
    step(CMD_WR, 8, 8'hEE, 1, "R8");
    drain();
    rd_burst(8, "R8");
    drain();

    // R8/R7: activate attempts during a write burst are dropped
    wr_burst(0, 8'h30, CMD_ACT);
    rd_burst(1, "R7");
    drain();

    // R3: rows are separate
    act(5);
    wr_burst(4, 8'h50, CMD_NOP);
    act(2);
    rd_burst(4, "R3");
    drain();
    act(5);
    rd_burst(5, "R3");
    drain();

    // R10: refresh counter sequence and wrap; R1: starts at 0
    for (int k = 0; k <= ROWS; k++) begin
      step(CMD_REF, 0, 0, 0, "R10");
      @(negedge clk);
      chk(ref_done == 1'b1, "R10", "ref_done pulse", ref_done, 1);
      chk(ref_row == 3'(k % ROWS), k == 0 ? "R1" : "R10", "ref_row", ref_row, k % ROWS);
      @(negedge clk);
      chk(ref_done == 1'b0, "R10", "ref_done width", ref_done, 0);
    end

    // R9/R10: refresh closed the row; read and write are ignored
    seen = rv_cnt;
    step(CMD_RD, 6, 0);
    step(CMD_WR, 6, 8'hEE);
    repeat (8) @(negedge clk);
    chk(rv_cnt == seen, "R9", "read after refresh", rv_cnt - seen, 0);
    act(5);
    rd_burst(6, "R9");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule